// File: doc/BRIEF.md
# Programmable Pin Cell

This block is a single configurable I/O cell for a programmable logic fabric. Three things meet in it: the logic that feeds the pin (`core_out`), the fabric's input network (`core_in`), and the pad (`pad_in`, `pad_out`, `pad_oe`). A static mode field turns the cell into one of five pin types:

- a plain input;
- a sampled input;
- a transparent-latch input;
- an always-driven output;
- a three-state bidirectional pin.

In bidirectional mode the cell chooses its driver enable from a set of candidate enables. Two of them are chip-wide and five are generated by logic blocks. One more selection code forces the driver on.

The cell's sampling element runs on the system clock. One of two I/O clock strobes qualifies it. That one flop is the input register in sampled mode and the hold stage in latch mode. A synchronous active-low reset clears it. An active-low test enable turns the driver off in every mode and with every enable selection.

Top module: `pgm_pin_cell`

## Requirements
- R1: `cfg_mode` encoding: 0 plain input, 1 sampled input, 2 latched input, 3 output, 4 bidirectional. In modes 0, 1 and 2 `pad_oe` is 0 whatever `cfg_oe_src` and the enables are.
- R2: In plain-input mode `core_in` equals `pad_in` in the same cycle.
- R3: In sampled-input mode `core_in` shows the value `pad_in` had at the last rising `clk` edge where the selected strobe was high. Edges where the strobe is low leave it unchanged.
- R4: In latched-input mode `core_in` follows `pad_in` while the selected strobe is high. While the strobe is low it holds the value captured at the last edge where the strobe was high.
- R5: `cfg_clk_src` selects which bit of `ioclk_tick` qualifies sampling: 0 selects bit 0 and 1 selects bit 1. The other bit has no effect.
- R6: A rising `clk` edge with `rst_n` low clears the captured value to 0. This shows as `core_in` = 0 in sampled mode, and in latched mode while the strobe is low.
- R7: In output mode `pad_out` equals `core_out`, `pad_oe` is 1 when `test_oe_n` is high, and `core_in` is 0.
- R8: In bidirectional mode `pad_out` equals `core_out`, `pad_oe` equals the selected enable, and `core_in` equals `pad_in`.
- R9: `cfg_oe_src` codes 0–1 select `glb_oe[code]`, codes 2–6 select `blk_oe[code-2]`, and code 7 selects a constant 1.
- R10: While `test_oe_n` is 0, `pad_oe` is 0 in every mode.
- R11: Mode codes 5–7 behave as plain input. In every mode other than output and bidirectional, `pad_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Pin mode code |
| cfg_oe_src | input | 3 | Enable source selection code |
| cfg_clk_src | input | 1 | I/O clock strobe selection |
| ioclk_tick | input | 2 | The two I/O clock strobes |
| glb_oe | input | 2 | Chip-wide output enables |
| blk_oe | input | 5 | Logic-block generated output enables |
| test_oe_n | input | 1 | Active-low test enable, driver off when 0 |
| core_out | input | 1 | Value to drive onto the pin |
| core_in | output | 1 | Value sent to the fabric input network |
| pad_in | input | 1 | Value sensed at the pad |
| pad_out | output | 1 | Value presented to the pad driver |
| pad_oe | output | 1 | Pad driver enable |

## Verification
The bench steps through every mode code with both strobe selections. For each combination it applies random pad, strobe, enable and test-enable patterns, with short resets scattered through the run.

- Strobes that are high only on the unselected bit show whether sampling obeys `cfg_clk_src` or the wrong strobe.
- Cycles where the strobe is low separate a latch that holds correctly from one that stays transparent.
- Randomising every enable line while `cfg_oe_src` sweeps all eight codes shows off-by-one errors in the enable map.
- Pulling `test_oe_n` low in output mode tells the override apart from the mode's own forced drive.

// File: rtl/pgm_pin_cell_pkg.sv
// Shared definitions for the programmable pin cell.
// Assumes mode and enable-source codes are static configuration.
package pgm_pin_cell_pkg;

    typedef enum logic [2:0] {
        PM_IN_PLAIN  = 3'd0,
        PM_IN_SAMPLE = 3'd1,
        PM_IN_LATCH  = 3'd2,
        PM_OUT       = 3'd3,
        PM_BIDIR     = 3'd4
    } pin_mode_e;

    // True for the modes that may enable the pad driver.
    function automatic logic mode_drives(input logic [2:0] m);
        return (m == PM_OUT) || (m == PM_BIDIR);
    endfunction

endpackage

// File: rtl/pcell_oe_mux.sv
// Enable source selector: builds the candidate list (global enables,
// block enables, then constant one) and picks one by code.
// Assumes the code width covers every candidate; codes past the
// last block enable select the constant one.
module pcell_oe_mux #(
    parameter int N_GLB = 2,
    parameter int N_BLK = 5,
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [N_GLB-1:0] glb_oe,
    input  logic [N_BLK-1:0] blk_oe,
    output logic             oe_pick
);
    localparam int N_SRC  = N_GLB + N_BLK + 1;
    localparam int N_CODE = 1 << SEL_W;

    logic [N_CODE-1:0] cand;

    // Candidate vector assembled slot by slot.
    for (genvar i = 0; i < N_CODE; i++) begin : g_cand
        if (i < N_GLB) begin : g_glb
            assign cand[i] = glb_oe[i];
        end else if (i < N_GLB + N_BLK) begin : g_blk
            assign cand[i] = blk_oe[i-N_GLB];
        end else begin : g_one
            assign cand[i] = 1'b1;
        end
    end

    // Select the addressed candidate.
    always_comb begin
        oe_pick = cand[sel];
    end

    initial begin
        if (N_CODE < N_SRC) $error("pcell_oe_mux: SEL_W too small");
    end
endmodule

// File: rtl/pcell_capture.sv
// Input capture stage: one flop shared by the sampled and latched
// input modes, qualified by one of the I/O clock strobes.
// Assumes strobes are synchronous to clk; reset is synchronous, active low.
module pcell_capture #(
    parameter int N_IOCLK = 2,
    parameter int CSEL_W  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CSEL_W-1:0]  clk_src,
    input  logic [N_IOCLK-1:0] ioclk_tick,
    input  logic               pad_in,
    output logic               cap_q,
    output logic               latch_q
);
    logic sel_tick;

    // Pick the qualifying strobe.
    always_comb begin
        sel_tick = ioclk_tick[clk_src];
    end

    // Capture the pad on qualified edges, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_q <= 1'b0;
        else if (sel_tick) cap_q <= pad_in;
    end

    // Latch view: transparent during the strobe, held otherwise.
    always_comb begin
        latch_q = sel_tick ? pad_in : cap_q;
    end

    // R3
    sample_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_tick |=> (cap_q == $past(pad_in)));
    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_tick |=> $stable(cap_q));
    // R6
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cap_q == 1'b0));
endmodule

// File: rtl/pcell_drive.sv
// Pad driver control: decides pad value and driver enable from the
// mode, the chosen enable and the active-low test override.
// Assumes unlisted mode codes are input-only.
module pcell_drive (
    input  logic [2:0] mode,
    input  logic       oe_pick,
    input  logic       test_oe_n,
    input  logic       core_out,
    output logic       pad_out,
    output logic       pad_oe
);
    import pgm_pin_cell_pkg::*;

    logic mode_oe;

    // Mode-level enable before the test override.
    always_comb begin
        case (mode)
            PM_OUT:   mode_oe = 1'b1;
            PM_BIDIR: mode_oe = oe_pick;
            default:  mode_oe = 1'b0;
        endcase
    end

    // Driver outputs with the override applied last.
    always_comb begin
        pad_out = mode_drives(mode) ? core_out : 1'b0;
        pad_oe  = mode_oe & test_oe_n;
    end
endmodule

// File: rtl/pgm_pin_cell.sv
// Programmable pin cell top: wires the enable selector, capture stage
// and driver control, and steers the fabric-side input by mode.
// Assumes configuration inputs are static between resets.
module pgm_pin_cell #(
    parameter int N_GLB   = 2,
    parameter int N_BLK   = 5,
    parameter int N_IOCLK = 2,
    localparam int OSEL_W = $clog2(N_GLB + N_BLK + 1),
    localparam int CSEL_W = (N_IOCLK > 1) ? $clog2(N_IOCLK) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cfg_mode,
    input  logic [OSEL_W-1:0]  cfg_oe_src,
    input  logic [CSEL_W-1:0]  cfg_clk_src,
    input  logic [N_IOCLK-1:0] ioclk_tick,
    input  logic [N_GLB-1:0]   glb_oe,
    input  logic [N_BLK-1:0]   blk_oe,
    input  logic               test_oe_n,
    input  logic               core_out,
    output logic               core_in,
    input  logic               pad_in,
    output logic               pad_out,
    output logic               pad_oe
);
    import pgm_pin_cell_pkg::*;

    logic oe_pick;
    logic cap_q;
    logic latch_q;

    pcell_oe_mux #(.N_GLB(N_GLB), .N_BLK(N_BLK), .SEL_W(OSEL_W)) oe_mux_i (
        .sel     (cfg_oe_src),
        .glb_oe  (glb_oe),
        .blk_oe  (blk_oe),
        .oe_pick (oe_pick)
    );

    pcell_capture #(.N_IOCLK(N_IOCLK), .CSEL_W(CSEL_W)) capture_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_src    (cfg_clk_src),
        .ioclk_tick (ioclk_tick),
        .pad_in     (pad_in),
        .cap_q      (cap_q),
        .latch_q    (latch_q)
    );

    pcell_drive drive_i (
        .mode      (cfg_mode),
        .oe_pick   (oe_pick),
        .test_oe_n (test_oe_n),
        .core_out  (core_out),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    // Steer the fabric-side input according to the mode.
    always_comb begin
        case (cfg_mode)
            PM_IN_SAMPLE: core_in = cap_q;
            PM_IN_LATCH:  core_in = latch_q;
            PM_OUT:       core_in = 1'b0;
            default:      core_in = pad_in;
        endcase
    end

    // R10
    test_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !test_oe_n |-> !pad_oe);
    // R1
    input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == PM_IN_PLAIN || cfg_mode == PM_IN_SAMPLE ||
         cfg_mode == PM_IN_LATCH) |-> !pad_oe);
    // R7
    out_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == PM_OUT && test_oe_n) |-> pad_oe);
    // R8
    bidir_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == PM_BIDIR) |-> (core_in == pad_in));
endmodule

// File: tb/pgm_pin_cell_tb_top.sv
module pgm_pin_cell_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cfg_mode;
    logic [2:0] cfg_oe_src;
    logic       cfg_clk_src;
    logic [1:0] ioclk_tick;
    logic [1:0] glb_oe;
    logic [4:0] blk_oe;
    logic       test_oe_n;
    logic       core_out;
    logic       core_in;
    logic       pad_in;
    logic       pad_out;
    logic       pad_oe;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    int cap_m = 0;   // reference model of the captured value

    always #4 clk = ~clk;

    pgm_pin_cell dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_oe_src(cfg_oe_src),
        .cfg_clk_src(cfg_clk_src), .ioclk_tick(ioclk_tick), .glb_oe(glb_oe),
        .blk_oe(blk_oe), .test_oe_n(test_oe_n), .core_out(core_out),
        .core_in(core_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b (mode %0d src %0d csel %0d t=%0t)",
                     req, act, exp, cfg_mode, cfg_oe_src, cfg_clk_src, $time);
        end
    endtask

    // Expected values from the requirements.
    function automatic int exp_oe();
        int en;
        if (cfg_oe_src < 2)      en = glb_oe[cfg_oe_src];      // R9
        else if (cfg_oe_src < 7) en = blk_oe[cfg_oe_src - 2];
        else                     en = 1;
        if (!test_oe_n) return 0;                              // R10
        if (cfg_mode == 3) return 1;                           // R7
        if (cfg_mode == 4) return en;                          // R8
        return 0;                                              // R1
    endfunction

    function automatic int exp_in();
        int tk = ioclk_tick[cfg_clk_src];                      // R5
        case (cfg_mode)
            1: return cap_m;                                   // R3
            2: return tk ? pad_in : cap_m;                     // R4
            3: return 0;                                       // R7
            default: return pad_in;                            // R2 R8 R11
        endcase
    endfunction

    function automatic string tag_in();
        case (cfg_mode)
            0: return "R2";
            1: return "R3 R5 R6";
            2: return "R4 R5 R6";
            3: return "R7";
            4: return "R8";
            default: return "R11";
        endcase
    endfunction

    function automatic string tag_oe();
        if (!test_oe_n) return "R10";
        if (cfg_mode == 4) return "R9";
        if (cfg_mode == 3) return "R7";
        return "R1";
    endfunction

    task automatic compare_all();
        chk(tag_in(), core_in, exp_in()[0]);
        chk(tag_oe(), pad_oe, exp_oe()[0]);
        chk((cfg_mode == 3 || cfg_mode == 4) ? "R7 R8" : "R11", pad_out,
            (cfg_mode == 3 || cfg_mode == 4) ? core_out : 1'b0);
    endtask

    // Drive at negedge, compare before the edge, update model after it.
    task automatic step();
        @(negedge clk);
        #2;
        compare_all();
        @(posedge clk);
        if (!rst_n) cap_m = 0;
        else if (ioclk_tick[cfg_clk_src]) cap_m = pad_in;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 0; cfg_mode = 3'd1; cfg_oe_src = 3'd7; cfg_clk_src = 0;
        ioclk_tick = 2'b11; glb_oe = 0; blk_oe = 0; test_oe_n = 1;
        core_out = 0; pad_in = 1;
        repeat (3) step();
        // Reset state: sampled mode reads 0 after reset (R6), driver off (R1).
        @(negedge clk);
        rst_n = 1; ioclk_tick = 2'b00;
        #2;
        chk("R6", core_in, 1'b0);
        chk("R1", pad_oe, 1'b0);
        @(posedge clk);
        for (int m = 0; m < 8; m++) begin
            for (int cs = 0; cs < 2; cs++) begin
                for (int n = 0; n < 250; n++) begin
                    @(negedge clk);
                    cfg_mode    = 3'(m);
                    cfg_clk_src = cs[0];
                    cfg_oe_src  = 3'(n % 8);
                    rst_n       = ($urandom_range(0, 39) != 0);
                    ioclk_tick  = 2'($urandom_range(0, 3));
                    glb_oe      = 2'($urandom_range(0, 3));
                    blk_oe      = 5'($urandom_range(0, 31));
                    test_oe_n   = ($urandom_range(0, 5) != 0);
                    core_out    = 1'($urandom_range(0, 1));
                    pad_in      = 1'($urandom_range(0, 1));
                    #2;
                    compare_all();
                    @(posedge clk);
                    if (!rst_n) cap_m = 0;
                    else if (ioclk_tick[cfg_clk_src]) cap_m = pad_in;
                end
            end
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule